// File: doc/BRIEF.md
# Flash command sequence decoder

This block turns the stream of bus writes aimed at a byte-wide parallel NOR flash model into single-cycle commands for the embedded program/erase engine. Every command except the one-write read/reset and the erase suspend/resume pair must start with a two-write unlock prefix at fixed low addresses. Erase commands need a setup byte and a second unlock before the final byte. The decoder latches the target byte address and data for a program. It latches the sector number for a sector erase. It also tells the read path whether reads should come from the array or from the identification space.

Each write is a clean, synchronous strobe with a 20-bit address and an 8-bit data byte. The engine reports a single busy flag. The decoder remembers which operation it launched last, so it can decide which writes a busy engine still accepts. A small readback function produces the identification byte: a maker code, a part code, or the protection state of one sector group. The read multiplexer selects this byte while the identification mode flag is high.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), no command pulse is high and id_mode is 0 (array reads).
- R2: The unlock prefix is data AAh at address 555h followed by data 55h at address 2AAh. Only address bits 10:0 are compared, and bits 19:11 may hold any value.
- R3: After the unlock, data A0h at 555h arms a program. The next write of any data, F0h included, pulses cmd_prog one cycle after that write. prog_addr and prog_data then show that write's address and data, and they hold until prog_ack. Writes before prog_ack are ignored.
- R4: Unlock, 80h at 555h, unlock again, then 10h at 555h pulses cmd_chip_erase.
- R5: Unlock, 80h at 555h, unlock again, then 30h at any address pulses cmd_sect_erase. sect_sel takes address bits 19:16 of that last write.
- R6: Unlock, then 90h at 555h, pulses cmd_id and sets id_mode to 1. id_data reads C2h for id_sel=00 and D5h for id_sel=01. When id_sel[1]=1, id_data reads 01h if grp_prot[id_grp] is 1 and 00h if it is 0.
- R7: Data F0h at any address pulses cmd_reset and clears id_mode. This holds at every point of a sequence except the write that follows a program arm.
- R8: Any write that breaks the expected address/data sequence returns the decoder to its first step and clears id_mode, with no pulse.
- R9: While eng_busy is 1 after a program or chip erase, every write is ignored. No pulse occurs and the sequence step does not change.
- R10: While eng_busy is 1 after a sector erase, data B0h pulses cmd_suspend. Every other write is ignored.
- R11: Data 30h as the first write of a sequence pulses cmd_resume only while an erase is suspended. Otherwise it is an ordinary wrong write. A suspended erase still allows a program sequence, but an erase setup (80h) aborts.
- R12: Each command pulse lasts exactly one cycle, and at most one command pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data |
| eng_busy | input | 1 | Embedded algorithm engine is running |
| prog_ack | input | 1 | Engine has taken the program address and data |
| id_sel | input | 2 | Read address bits 1:0 for the identification space |
| id_grp | input | 3 | Read address bits 19:17, the sector group being queried |
| grp_prot | input | 8 | Protection state, one bit per sector group |
| cmd_reset | output | 1 | Read/reset command pulse |
| cmd_id | output | 1 | Identification mode entry pulse |
| cmd_prog | output | 1 | Program command pulse |
| cmd_chip_erase | output | 1 | Chip erase command pulse |
| cmd_sect_erase | output | 1 | Sector erase command pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| prog_addr | output | 20 | Latched program address |
| prog_data | output | 8 | Latched program data |
| sect_sel | output | 4 | Latched sector number for a sector erase |
| id_mode | output | 1 | 1: reads come from the identification space, 0: from the array |
| id_data | output | 8 | Identification byte for the current id_sel/id_grp |

## Verification
The assertions assume an engine that raises eng_busy in the cycle after a program or erase pulse, before the next write arrives. They also assume prog_ack only answers a pending program. The stimulus spaces every write by two idle cycles and holds eng_busy steady across each write, so busy windows never race a launch. The sweeps cover every sector number, every sector-group protection bit, and every data byte that can break the second unlock write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM_ARM, ST_ERS_SET, ST_ERS_UNL1, ST_ERS_UNL2
   } step_t;

   typedef enum logic [1:0] {OP_NONE, OP_PGM, OP_CHIP, OP_SECT} op_t;

   typedef struct packed {
      logic rst;
      logic id;
      logic pgm;
      logic chip;
      logic sect;
      logic susp;
      logic res;
   } cmd_pulse_t;

   // pattern indices
   localparam int P_UNL_A = 0;
   localparam int P_UNL_B = 1;
   localparam int P_PGM   = 2;
   localparam int P_ERS   = 3;
   localparam int P_ID    = 4;
   localparam int P_CHIP  = 5;
   localparam int P_RST   = 6;
   localparam int P_SUSP  = 7;
   localparam int P_CONF  = 8;   // 30h: sector confirm or resume
   localparam int NPAT    = 9;

   function automatic logic [31:0] pat_data(input int i);
      case (i)
         P_UNL_A: return 32'hAA;
         P_UNL_B: return 32'h55;
         P_PGM:   return 32'hA0;
         P_ERS:   return 32'h80;
         P_ID:    return 32'h90;
         P_CHIP:  return 32'h10;
         P_RST:   return 32'hF0;
         P_SUSP:  return 32'hB0;
         default: return 32'h30;
      endcase
   endfunction

   function automatic logic [31:0] pat_addr(input int i);
      return (i == P_UNL_B) ? 32'h2AA : 32'h555;
   endfunction

   function automatic bit pat_uses_addr(input int i);
      return (i <= P_CHIP);
   endfunction

endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
   parameter int          CMP_W    = 11,
   parameter int          DATA_W   = 8,
   parameter logic [31:0] REF_ADDR = 32'h555,
   parameter logic [31:0] REF_DATA = 32'hAA,
   parameter bit          USE_ADDR = 1'b1
) (
   input  logic [CMP_W-1:0]  addr_lo,
   input  logic [DATA_W-1:0] data,
   output logic              hit
);
   localparam logic [CMP_W-1:0] AMASK = USE_ADDR ? {CMP_W{1'b1}} : '0;
   localparam logic [CMP_W-1:0] AREF  = REF_ADDR[CMP_W-1:0];

   assign hit = (data == REF_DATA[DATA_W-1:0]) &&
                ((addr_lo & AMASK) == (AREF & AMASK));
endmodule

// File: rtl/fcd_id_readback.sv
module fcd_id_readback #(
   parameter int          DATA_W   = 8,
   parameter int          GRP_BITS = 3,
   parameter logic [7:0]  MFR_ID   = 8'hC2,
   parameter logic [7:0]  DEV_ID   = 8'hD5,
   localparam int         NGRP     = 1 << GRP_BITS
) (
   input  logic [1:0]          sel,
   input  logic [GRP_BITS-1:0] grp,
   input  logic [NGRP-1:0]     prot,
   output logic [DATA_W-1:0]   data
);
   always_comb begin
      data = '0;
      if (sel[1])
         data[0] = prot[grp];
      else if (sel[0])
         data[7:0] = DEV_ID;
      else
         data[7:0] = MFR_ID;
   end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import fcd_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NPAT-1:0]   hit,
   input  logic              eng_busy,
   input  logic              prog_ack,
   output cmd_pulse_t        pulse,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic [SECT_BITS-1:0] sect_sel,
   output logic              id_mode
);
   step_t      step_q, step_n;
   op_t        op_q, op_n;
   logic       susp_q, susp_n, pend_q, pend_n, mode_n;
   cmd_pulse_t pulse_n;
   logic [ADDR_W-1:0]    pa_n;
   logic [DATA_W-1:0]    pd_n;
   logic [SECT_BITS-1:0] ss_n;
   logic                 blocked;

   assign blocked = eng_busy | pend_q;

   always_comb begin
      step_n  = step_q;
      op_n    = op_q;
      susp_n  = susp_q;
      pend_n  = pend_q & ~prog_ack;
      mode_n  = id_mode;
      pulse_n = '0;
      pa_n    = prog_addr;
      pd_n    = prog_data;
      ss_n    = sect_sel;
      if (wr_en) begin
         if (blocked) begin
            if (eng_busy && op_q == OP_SECT && !susp_q && hit[P_SUSP]) begin
               pulse_n.susp = 1'b1;
               susp_n       = 1'b1;
            end
         end else if (step_q == ST_PGM_ARM) begin
            pulse_n.pgm = 1'b1;
            pa_n        = wr_addr;
            pd_n        = wr_data;
            pend_n      = 1'b1;
            op_n        = OP_PGM;
            step_n      = ST_IDLE;
         end else if (hit[P_RST]) begin
            pulse_n.rst = 1'b1;
            mode_n      = 1'b0;
            step_n      = ST_IDLE;
         end else if (step_q == ST_IDLE && susp_q && hit[P_CONF]) begin
            pulse_n.res = 1'b1;
            susp_n      = 1'b0;
            op_n        = OP_SECT;
         end else begin
            // default: abort to first step and array reads
            step_n = ST_IDLE;
            mode_n = 1'b0;
            unique case (step_q)
               ST_IDLE:     if (hit[P_UNL_A]) begin step_n = ST_UNL1; mode_n = id_mode; end
               ST_UNL1:     if (hit[P_UNL_B]) begin step_n = ST_UNL2; mode_n = id_mode; end
               ST_UNL2: begin
                  if (hit[P_PGM]) begin
                     step_n = ST_PGM_ARM; mode_n = id_mode;
                  end else if (hit[P_ERS] && !susp_q) begin
                     step_n = ST_ERS_SET; mode_n = id_mode;
                  end else if (hit[P_ID]) begin
                     pulse_n.id = 1'b1; mode_n = 1'b1;
                  end
               end
               ST_ERS_SET:  if (hit[P_UNL_A]) begin step_n = ST_ERS_UNL1; mode_n = id_mode; end
               ST_ERS_UNL1: if (hit[P_UNL_B]) begin step_n = ST_ERS_UNL2; mode_n = id_mode; end
               ST_ERS_UNL2: begin
                  if (hit[P_CHIP]) begin
                     pulse_n.chip = 1'b1; op_n = OP_CHIP; mode_n = id_mode;
                  end else if (hit[P_CONF]) begin
                     pulse_n.sect = 1'b1; op_n = OP_SECT; mode_n = id_mode;
                     ss_n = wr_addr[ADDR_W-1 -: SECT_BITS];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q    <= ST_IDLE;
         op_q      <= OP_NONE;
         susp_q    <= 1'b0;
         pend_q    <= 1'b0;
         id_mode   <= 1'b0;
         pulse     <= '0;
         prog_addr <= '0;
         prog_data <= '0;
         sect_sel  <= '0;
      end else begin
         step_q    <= step_n;
         op_q      <= op_n;
         susp_q    <= susp_n;
         pend_q    <= pend_n;
         id_mode   <= mode_n;
         pulse     <= pulse_n;
         prog_addr <= pa_n;
         prog_data <= pd_n;
         sect_sel  <= ss_n;
      end
   end

   // R12: never two commands at once
   p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pulse));

   // R12: a program pulse never repeats in the next cycle
   p_prog_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.pgm |=> !pulse.pgm);

   // R3: latched program target stays put until the engine takes it
   p_prog_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !prog_ack) |=> ($stable(prog_addr) && $stable(prog_data)));

   // R9: busy after program or chip erase silences every command
   p_busy_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && op_q != OP_SECT) |=> (pulse == '0));

   // R10: suspend only comes out of a busy engine
   p_susp_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.susp |-> $past(eng_busy));

   // R11: resume only from a suspended erase
   p_resume_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.res |-> $past(susp_q));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int         ADDR_W    = 20,
   parameter int         DATA_W    = 8,
   parameter int         CMP_W     = 11,
   parameter int         SECT_BITS = 4,
   parameter logic [7:0] MFR_ID    = 8'hC2,
   parameter logic [7:0] DEV_ID    = 8'hD5,
   localparam int        GRP_BITS  = SECT_BITS - 1,
   localparam int        NGRP      = 1 << GRP_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 eng_busy,
   input  logic                 prog_ack,
   input  logic [1:0]           id_sel,
   input  logic [GRP_BITS-1:0]  id_grp,
   input  logic [NGRP-1:0]      grp_prot,
   output logic                 cmd_reset,
   output logic                 cmd_id,
   output logic                 cmd_prog,
   output logic                 cmd_chip_erase,
   output logic                 cmd_sect_erase,
   output logic                 cmd_suspend,
   output logic                 cmd_resume,
   output logic [ADDR_W-1:0]    prog_addr,
   output logic [DATA_W-1:0]    prog_data,
   output logic [SECT_BITS-1:0] sect_sel,
   output logic                 id_mode,
   output logic [DATA_W-1:0]    id_data
);
   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold an 8-bit command byte");
   end
   if (CMP_W < 11 || CMP_W > ADDR_W) begin : g_bad_cmp
      $error("CMP_W must cover the unlock addresses and fit in ADDR_W");
   end
   if (SECT_BITS < 2 || SECT_BITS > ADDR_W) begin : g_bad_sect
      $error("SECT_BITS must be between 2 and ADDR_W");
   end

   logic [NPAT-1:0] hit;
   cmd_pulse_t      pulse;

   for (genvar i = 0; i < NPAT; i++) begin : g_pat
      fcd_match #(
         .CMP_W    (CMP_W),
         .DATA_W   (DATA_W),
         .REF_ADDR (pat_addr(i)),
         .REF_DATA (pat_data(i)),
         .USE_ADDR (pat_uses_addr(i))
      ) u_match (
         .addr_lo (wr_addr[CMP_W-1:0]),
         .data    (wr_data),
         .hit     (hit[i])
      );
   end

   fcd_seq_fsm #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SECT_BITS (SECT_BITS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .hit       (hit),
      .eng_busy  (eng_busy),
      .prog_ack  (prog_ack),
      .pulse     (pulse),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .sect_sel  (sect_sel),
      .id_mode   (id_mode)
   );

   fcd_id_readback #(
      .DATA_W   (DATA_W),
      .GRP_BITS (GRP_BITS),
      .MFR_ID   (MFR_ID),
      .DEV_ID   (DEV_ID)
   ) u_idrb (
      .sel  (id_sel),
      .grp  (id_grp),
      .prot (grp_prot),
      .data (id_data)
   );

   assign cmd_reset      = pulse.rst;
   assign cmd_id         = pulse.id;
   assign cmd_prog       = pulse.pgm;
   assign cmd_chip_erase = pulse.chip;
   assign cmd_sect_erase = pulse.sect;
   assign cmd_suspend    = pulse.susp;
   assign cmd_resume     = pulse.res;
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [19:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        eng_busy = 0;
   logic        prog_ack = 0;
   logic [1:0]  id_sel = '0;
   logic [2:0]  id_grp = '0;
   logic [7:0]  grp_prot = '0;
   logic        cmd_reset, cmd_id, cmd_prog, cmd_chip_erase, cmd_sect_erase, cmd_suspend, cmd_resume;
   logic [19:0] prog_addr;
   logic [7:0]  prog_data, id_data;
   logic [3:0]  sect_sel;
   logic        id_mode;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [6:0] NONE = 7'b0000000;
   localparam logic [6:0] K_RST = 7'b1000000;
   localparam logic [6:0] K_ID  = 7'b0100000;
   localparam logic [6:0] K_PGM = 7'b0010000;
   localparam logic [6:0] K_CHP = 7'b0001000;
   localparam logic [6:0] K_SEC = 7'b0000100;
   localparam logic [6:0] K_SUS = 7'b0000010;
   localparam logic [6:0] K_RES = 7'b0000001;

   wire [6:0] pv = {cmd_reset, cmd_id, cmd_prog, cmd_chip_erase, cmd_sect_erase, cmd_suspend, cmd_resume};

   always #2 clk = ~clk;

   flash_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .eng_busy(eng_busy), .prog_ack(prog_ack), .id_sel(id_sel), .id_grp(id_grp),
      .grp_prot(grp_prot), .cmd_reset(cmd_reset), .cmd_id(cmd_id), .cmd_prog(cmd_prog),
      .cmd_chip_erase(cmd_chip_erase), .cmd_sect_erase(cmd_sect_erase),
      .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .prog_addr(prog_addr),
      .prog_data(prog_data), .sect_sel(sect_sel), .id_mode(id_mode), .id_data(id_data)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one write; pulse sampled the cycle after, then checked gone (R12)
   task automatic wr(input logic [19:0] a, input logic [7:0] d, input logic [6:0] exp, input string req);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      chk({25'd0, pv}, {25'd0, exp}, req);
      @(negedge clk);
      chk({25'd0, pv}, 32'd0, "R12 pulse lasts one cycle");
   endtask

   task automatic unlock(input logic [19:0] hi, input string req);
      wr(hi | 20'h555, 8'hAA, NONE, req);
      wr(hi | 20'h2AA, 8'h55, NONE, req);
   endtask

   task automatic ack;
      @(negedge clk); prog_ack = 1;
      @(negedge clk); prog_ack = 0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({25'd0, pv}, 32'd0, "R1 no pulse after reset");
      chk({31'd0, id_mode}, 32'd0, "R1 array mode after reset");
      rst_n = 1;

      // R2 with high address bits set, R6 entry
      wr(20'hFF555, 8'hAA, NONE, "R2 unlock first");
      wr(20'h7A2AA, 8'h55, NONE, "R2 unlock second");
      wr(20'h80555, 8'h90, K_ID, "R6 id entry");
      chk({31'd0, id_mode}, 32'd1, "R6 id mode set");

      // R6 id readback sweep
      for (int g = 0; g < 8; g++) begin
         for (int pat = 0; pat < 2; pat++) begin
            @(negedge clk);
            grp_prot = pat[0] ? 8'h5A : 8'hA5;
            id_grp = g[2:0];
            id_sel = 2'b10 | 2'(g & 1);
            #1 chk({24'd0, id_data}, {31'd0, grp_prot[g]}, "R6 protect state");
         end
         @(negedge clk);
         id_sel = 2'b00;
         #1 chk({24'd0, id_data}, 32'hC2, "R6 maker code");
         id_sel = 2'b01;
         #1 chk({24'd0, id_data}, 32'hD5, "R6 part code");
      end

      // R7 reset from id mode and from mid-sequence
      wr(20'hABCDE, 8'hF0, K_RST, "R7 reset command");
      chk({31'd0, id_mode}, 32'd0, "R7 array mode after reset");
      unlock(20'h0, "R2 unlock");
      wr(20'h00555, 8'h80, NONE, "R4 erase setup");
      wr(20'h12345, 8'hF0, K_RST, "R7 reset mid-erase");
      wr(20'h00555, 8'hAA, NONE, "R7 step restarted");
      wr(20'h002AA, 8'h55, NONE, "R7 step restarted");
      wr(20'h00555, 8'h10, NONE, "R7 old setup discarded");

      // R3 program, hold until ack
      unlock(20'h0, "R2 unlock");
      wr(20'h00555, 8'hA0, NONE, "R3 arm");
      wr(20'h12345, 8'h3C, K_PGM, "R3 program pulse");
      chk({12'd0, prog_addr}, 32'h12345, "R3 program address");
      chk({24'd0, prog_data}, 32'h3C, "R3 program data");
      unlock(20'h0, "R3 ignored before ack");
      wr(20'h00555, 8'h90, NONE, "R3 ignored before ack");
      wr(20'h00555, 8'hF0, NONE, "R3 ignored before ack");
      chk({12'd0, prog_addr}, 32'h12345, "R3 address held");
      chk({24'd0, prog_data}, 32'h3C, "R3 data held");
      chk({31'd0, id_mode}, 32'd0, "R3 mode untouched");
      ack();
      unlock(20'h0, "R2 unlock");
      wr(20'h00555, 8'hA0, NONE, "R3 arm");
      wr(20'hFEDCB, 8'hF0, K_PGM, "R3 F0 programmed as data");
      chk({24'd0, prog_data}, 32'hF0, "R3 F0 data");
      chk({12'd0, prog_addr}, 32'hFEDCB, "R3 address");
      ack();

      // R4 chip erase, R9 busy ignores everything
      unlock(20'h0, "R2 unlock");
      wr(20'h00555, 8'h80, NONE, "R4 setup");
      unlock(20'h0, "R4 second unlock");
      wr(20'h00555, 8'h10, K_CHP, "R4 chip erase");
      eng_busy = 1;
      unlock(20'h0, "R9 busy unlock ignored");
      wr(20'h00555, 8'h90, NONE, "R9 busy id ignored");
      wr(20'h00000, 8'hB0, NONE, "R9 suspend ignored in chip erase");
      wr(20'h00000, 8'hF0, NONE, "R9 reset ignored");
      eng_busy = 0;
      wr(20'h00555, 8'h90, NONE, "R9 step unchanged by busy writes");
      chk({31'd0, id_mode}, 32'd0, "R9 mode unchanged");

      // R5 sector erase sweep
      for (int s = 0; s < 16; s++) begin
         unlock(20'h0, "R2 unlock");
         wr(20'h00555, 8'h80, NONE, "R5 setup");
         unlock(20'h0, "R5 second unlock");
         wr({s[3:0], 16'h1234}, 8'h30, K_SEC, "R5 sector erase");
         chk({28'd0, sect_sel}, s, "R5 sector number");
      end

      // R10 suspend, R11 resume
      eng_busy = 1;
      wr(20'h00555, 8'hAA, NONE, "R10 other write ignored");
      wr(20'h00000, 8'hF0, NONE, "R10 reset ignored");
      wr(20'h54321, 8'hB0, K_SUS, "R10 suspend");
      eng_busy = 0;
      unlock(20'h0, "R11 program while suspended");
      wr(20'h00555, 8'hA0, NONE, "R11 arm while suspended");
      wr(20'h20001, 8'h77, K_PGM, "R11 program while suspended");
      ack();
      unlock(20'h0, "R2 unlock");
      wr(20'h00555, 8'h80, NONE, "R11 setup refused");
      unlock(20'h0, "R11 after refusal");
      wr(20'h00555, 8'h10, NONE, "R11 no chip erase");
      wr(20'h11111, 8'h30, K_RES, "R11 resume");
      wr(20'h11111, 8'h30, NONE, "R11 resume without suspend");

      // R8 abort sweep on second unlock byte
      unlock(20'h0, "R2 unlock");
      wr(20'h00555, 8'h90, K_ID, "R6 id entry");
      for (int d = 0; d < 256; d++) begin
         if (d != 8'h55 && d != 8'hF0) begin
            wr(20'h00555, 8'hAA, NONE, "R8 first");
            wr(20'h002AA, d[7:0], NONE, "R8 wrong data");
            chk({31'd0, id_mode}, 32'd0, "R8 mode cleared");
            wr(20'h00555, 8'h90, NONE, "R8 sequence restarted");
         end
      end
      wr(20'h00555, 8'hAA, NONE, "R8 first");
      wr(20'h002AB, 8'h55, NONE, "R8 wrong address");
      wr(20'h00555, 8'h90, NONE, "R8 wrong address aborts");
      wr(20'h00554, 8'hAA, NONE, "R8 wrong first address");
      wr(20'h002AA, 8'h55, NONE, "R8 wrong first address");
      wr(20'h00555, 8'h90, NONE, "R8 wrong first address aborts");

      // R1 reset mid-sequence
      unlock(20'h0, "R2 unlock");
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      chk({31'd0, id_mode}, 32'd0, "R1 mode after reset");
      wr(20'h00555, 8'h90, NONE, "R1 step cleared by reset");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule